// File: doc/BRIEF.md
# Deferred-Write Tag Table

This block records the address tags of cache lines that a running hardware transaction has written while postponing the request for exclusive ownership. Each lazy store presents a tag and a contention score from an outside predictor. If the tag is new and a slot is free, the tag and score go into the lowest free slot. If every slot is taken, the lowest-scored entry is pushed out. The new tag takes that slot, and the displaced tag leaves at once on a request port so that write permission for it can be acquired.

Two registers track the table's contents. One holds the index of the lowest-scored valid entry and the other holds the highest score present. Both are recomputed after every insert, delete or flush. A commit walker reads the slots one index at a time through a combinational read port. The tag of each valid slot is a line whose exclusive permission must be obtained before commit. A one-cycle flush empties the table when a transaction commits or aborts.

Top module: `dwt_table`

## Requirements
- R1: After reset the occupancy is 0, `evict_valid` is 0, `min_idx` is 0, `max_score` is 0 and no slot reads as valid.
- R2: An accepted insert (`ins_valid` and `ins_ready` high at a rising edge) of a tag not held by any valid slot, into a table that is not full, writes the tag and score into the lowest-numbered free slot. The slot reads back as valid with that tag and score from the next cycle.
- R3: An accepted insert whose tag matches a valid slot changes nothing: the occupancy and the stored score stay as they were.
- R4: From the cycle after any insert, delete or flush, `max_score` equals the largest score among valid slots, or 0 when the table is empty.
- R5: From the cycle after any insert, delete or flush, `min_idx` equals the index of the valid slot with the smallest score. Among equal scores the lowest index is chosen. The value is 0 when the table is empty.
- R6: An accepted insert of a new tag into a full table overwrites slot `min_idx` with the new tag and score, and the occupancy stays at ENTRIES. From the next cycle `evict_valid` is 1 and `evict_tag` carries the overwritten tag.
- R7: While `evict_valid` is 1 and `evict_ready` is 0, `evict_valid` and `evict_tag` hold their values, and `ins_ready` is 0. The request drops in the cycle after `evict_ready` is seen high.
- R8: A `del_valid` pulse whose tag matches a valid slot clears that slot. A delete of a tag that no valid slot holds changes nothing.
- R9: A delete takes precedence over an insert: `ins_ready` is 0 in any cycle where `del_valid` is 1, and an insert presented then is not taken.
- R10: A `flush` cycle clears every slot and sets `min_idx` and `max_score` to 0. `ins_ready` is 0 during that cycle, so an insert presented with the flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Lazy store insert request |
| ins_ready | output | 1 | Insert can be taken this cycle |
| ins_tag | input | TAG_W | Tag to insert |
| ins_score | input | SCORE_W | Contention score of the tag |
| del_valid | input | 1 | Delete request, one cycle per request |
| del_tag | input | TAG_W | Tag to delete |
| flush | input | 1 | Empty the table (commit or abort) |
| rd_idx | input | IDX_W | Slot selected for readout |
| rd_valid | output | 1 | Selected slot holds an entry |
| rd_tag | output | TAG_W | Tag of the selected slot |
| rd_score | output | SCORE_W | Score of the selected slot |
| evict_valid | output | 1 | Request for write permission of an evicted tag |
| evict_ready | input | 1 | Request accepted |
| evict_tag | output | TAG_W | Tag whose write permission is requested |
| count | output | CNT_W | Number of valid slots |
| min_idx | output | IDX_W | Index of the lowest-scored valid slot |
| max_score | output | SCORE_W | Highest score among valid slots |

## Verification
The bench fills the table with scores that include two pairs of equal values. A tie-break that preferred the higher index would report the wrong `min_idx`, and would later push out the wrong line on overflow. It overflows the table while it holds `evict_ready` low. A design that let the request drift or accepted a second insert would then show a changed `evict_tag`, or a missing entry in the eviction scoreboard. It presents duplicate tags, absent deletes, and a delete or a flush together with an insert. A design that made a duplicate slot, reused a wrong free slot, or let an insert slip through a flush or a delete would show a wrong occupancy or a wrong readout.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

  // Operation applied to the table in a cycle, in priority order.
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_DELETE = 2'd1,
    OP_FILL   = 2'd2,
    OP_SWAP   = 2'd3
  } dwt_op_e;

endpackage

// File: rtl/dwt_match.sv
module dwt_match #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            vld,
  input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]              probe,
  output logic                          hit,
  output logic [IDX_W-1:0]              hit_idx
);

  logic [ENTRIES-1:0] eq;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign eq[g] = vld[g] && (tags[g] == probe);
    end
  endgenerate

  // Tags are kept unique, so at most one bit of eq is set.
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (eq[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit = |eq;

endmodule

// File: rtl/dwt_rank.sv
module dwt_rank #(
  parameter int ENTRIES = 8,
  parameter int SCORE_W = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]              vld,
  input  logic [ENTRIES-1:0][SCORE_W-1:0] scores,
  output logic [IDX_W-1:0]                lo_idx,
  output logic [SCORE_W-1:0]              hi_score
);

  logic [SCORE_W-1:0] lo_score;
  logic               seen;

  // Strict comparisons keep the lowest index on ties.
  always_comb begin
    lo_idx   = '0;
    lo_score = '0;
    hi_score = '0;
    seen     = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld[i]) begin
        if (!seen || (scores[i] < lo_score)) begin
          lo_idx   = IDX_W'(i);
          lo_score = scores[i];
        end
        if (scores[i] > hi_score) hi_score = scores[i];
        seen = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dwt_table.sv
module dwt_table
  import dwt_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 20,
  parameter int SCORE_W = 4,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ins_valid,
  output logic               ins_ready,
  input  logic [TAG_W-1:0]   ins_tag,
  input  logic [SCORE_W-1:0] ins_score,
  input  logic               del_valid,
  input  logic [TAG_W-1:0]   del_tag,
  input  logic               flush,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_valid,
  output logic [TAG_W-1:0]   rd_tag,
  output logic [SCORE_W-1:0] rd_score,
  output logic               evict_valid,
  input  logic               evict_ready,
  output logic [TAG_W-1:0]   evict_tag,
  output logic [CNT_W-1:0]   count,
  output logic [IDX_W-1:0]   min_idx,
  output logic [SCORE_W-1:0] max_score
);

  // Slot state
  logic [ENTRIES-1:0]              vld_q, vld_d;
  logic [ENTRIES-1:0][TAG_W-1:0]   tag_q;
  logic [ENTRIES-1:0][SCORE_W-1:0] scr_q, scr_d;
  logic [ENTRIES-1:0]              wr_en;

  // Rank registers
  logic [IDX_W-1:0]   min_idx_q, min_idx_d;
  logic [SCORE_W-1:0] max_scr_q, max_scr_d;
  logic               rank_en;

  // Eviction request
  logic               ev_pend_q, ev_pend_d;
  logic [TAG_W-1:0]   ev_tag_q, ev_tag_d;
  logic               ev_tag_en;

  // Decode
  logic               ins_fire;
  logic               ins_hit, del_hit;
  logic [IDX_W-1:0]   ins_hit_idx, del_hit_idx;
  logic               free_any;
  logic [IDX_W-1:0]   free_idx;
  logic [IDX_W-1:0]   wr_idx;
  dwt_op_e            op;

  dwt_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_ins_match (
    .vld     (vld_q),
    .tags    (tag_q),
    .probe   (ins_tag),
    .hit     (ins_hit),
    .hit_idx (ins_hit_idx)
  );

  dwt_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_del_match (
    .vld     (vld_q),
    .tags    (tag_q),
    .probe   (del_tag),
    .hit     (del_hit),
    .hit_idx (del_hit_idx)
  );

  // Lowest free slot
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign ins_ready = !ev_pend_q && !del_valid && !flush;
  assign ins_fire  = ins_valid && ins_ready;

  always_comb begin
    op = OP_NONE;
    if (!flush) begin
      if (del_valid) begin
        if (del_hit) op = OP_DELETE;
      end else if (ins_fire && !ins_hit) begin
        op = free_any ? OP_FILL : OP_SWAP;
      end
    end
  end

  // Slot next state
  assign wr_idx = (op == OP_SWAP) ? min_idx_q : free_idx;

  always_comb begin
    vld_d = vld_q;
    wr_en = '0;
    if (flush) begin
      vld_d = '0;
    end else begin
      unique case (op)
        OP_DELETE: vld_d[del_hit_idx] = 1'b0;
        OP_FILL, OP_SWAP: begin
          vld_d[wr_idx] = 1'b1;
          wr_en[wr_idx] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_slot
      assign scr_d[g] = wr_en[g] ? ins_score : scr_q[g];

      always_ff @(posedge clk) begin
        if (wr_en[g]) begin
          tag_q[g] <= ins_tag;
          scr_q[g] <= ins_score;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // Rank registers follow the next-state table
  dwt_rank #(.ENTRIES(ENTRIES), .SCORE_W(SCORE_W)) u_rank (
    .vld      (vld_d),
    .scores   (scr_d),
    .lo_idx   (min_idx_d),
    .hi_score (max_scr_d)
  );

  assign rank_en = flush || (op != OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_idx_q <= '0;
      max_scr_q <= '0;
    end else if (rank_en) begin
      min_idx_q <= min_idx_d;
      max_scr_q <= max_scr_d;
    end
  end

  // Eviction request
  always_comb begin
    ev_pend_d = ev_pend_q;
    ev_tag_en = 1'b0;
    ev_tag_d  = tag_q[min_idx_q];
    if (op == OP_SWAP) begin
      ev_pend_d = 1'b1;
      ev_tag_en = 1'b1;
    end else if (ev_pend_q && evict_ready) begin
      ev_pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_pend_q <= 1'b0;
    else        ev_pend_q <= ev_pend_d;
  end

  always_ff @(posedge clk) begin
    if (ev_tag_en) ev_tag_q <= ev_tag_d;
  end

  // Outputs
  assign rd_valid    = vld_q[rd_idx];
  assign rd_tag      = tag_q[rd_idx];
  assign rd_score    = scr_q[rd_idx];
  assign evict_valid = ev_pend_q;
  assign evict_tag   = ev_tag_q;
  assign count       = CNT_W'($countones(vld_q));
  assign min_idx     = min_idx_q;
  assign max_score   = max_scr_q;

endmodule

// File: rtl/dwt_table_chk.sv
module dwt_table_chk #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 20,
  parameter int SCORE_W = 4,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ins_valid,
  input logic               ins_ready,
  input logic               ins_hit,
  input logic               del_valid,
  input logic               flush,
  input logic               evict_valid,
  input logic               evict_ready,
  input logic [TAG_W-1:0]   evict_tag,
  input logic [CNT_W-1:0]   count,
  input logic [IDX_W-1:0]   min_idx,
  input logic [SCORE_W-1:0] max_score
);

  assert_dup_noop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready && ins_hit) |=> $stable(count));

  assert_empty_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (max_score == '0));

  assert_empty_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (min_idx == '0));

  assert_swap_on_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready && !ins_hit && (count == CNT_W'(ENTRIES)))
      |=> (evict_valid && (count == CNT_W'(ENTRIES))));

  assert_evict_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid && !evict_ready) |=> (evict_valid && $stable(evict_tag)));

  assert_evict_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> !ins_ready);

  assert_del_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    del_valid |-> !ins_ready);

  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((count == '0) && (max_score == '0) && (min_idx == '0)));

endmodule

bind dwt_table dwt_table_chk #(
  .ENTRIES (ENTRIES),
  .TAG_W   (TAG_W),
  .SCORE_W (SCORE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ins_valid   (ins_valid),
  .ins_ready   (ins_ready),
  .ins_hit     (ins_hit),
  .del_valid   (del_valid),
  .flush       (flush),
  .evict_valid (evict_valid),
  .evict_ready (evict_ready),
  .evict_tag   (evict_tag),
  .count       (count),
  .min_idx     (min_idx),
  .max_score   (max_score)
);

// File: tb/dwt_table_bench.sv
module dwt_table_bench;

  localparam int ENTRIES = 8;
  localparam int TAG_W   = 20;
  localparam int SCORE_W = 4;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int CNT_W   = $clog2(ENTRIES + 1);

  logic               clk = 1'b0;
  logic               rst_n;
  logic               ins_valid, ins_ready;
  logic [TAG_W-1:0]   ins_tag;
  logic [SCORE_W-1:0] ins_score;
  logic               del_valid;
  logic [TAG_W-1:0]   del_tag;
  logic               flush;
  logic [IDX_W-1:0]   rd_idx;
  logic               rd_valid;
  logic [TAG_W-1:0]   rd_tag;
  logic [SCORE_W-1:0] rd_score;
  logic               evict_valid, evict_ready;
  logic [TAG_W-1:0]   evict_tag;
  logic [CNT_W-1:0]   count;
  logic [IDX_W-1:0]   min_idx;
  logic [SCORE_W-1:0] max_score;

  always #5 clk = ~clk;

  dwt_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .SCORE_W(SCORE_W)) u_dwt_table (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_tag(ins_tag), .ins_score(ins_score),
    .del_valid(del_valid), .del_tag(del_tag), .flush(flush),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_score(rd_score),
    .evict_valid(evict_valid), .evict_ready(evict_ready), .evict_tag(evict_tag),
    .count(count), .min_idx(min_idx), .max_score(max_score)
  );

  int n_chk  = 0;
  int n_fail = 0;
  logic [TAG_W-1:0] ev_q[$];

  // Reference model of the table contents
  bit               m_vld[ENTRIES];
  logic [TAG_W-1:0] m_tag[ENTRIES];
  int               m_scr[ENTRIES];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  function automatic int m_count();
    int c = 0;
    for (int i = 0; i < ENTRIES; i++) if (m_vld[i]) c++;
    return c;
  endfunction

  function automatic int m_min();
    int idx = 0;
    int best = 0;
    bit seen = 0;
    for (int i = 0; i < ENTRIES; i++)
      if (m_vld[i] && (!seen || m_scr[i] < best)) begin
        idx = i; best = m_scr[i]; seen = 1;
      end
    return idx;
  endfunction

  function automatic int m_max();
    int mx = 0;
    for (int i = 0; i < ENTRIES; i++) if (m_vld[i] && m_scr[i] > mx) mx = m_scr[i];
    return mx;
  endfunction

  function automatic int m_find(input logic [TAG_W-1:0] t);
    for (int i = 0; i < ENTRIES; i++) if (m_vld[i] && m_tag[i] == t) return i;
    return -1;
  endfunction

  task automatic check_rank(input string req);
    chk(count == CNT_W'(m_count()), req, "count", count, m_count());
    chk(max_score == SCORE_W'(m_max()), "R4", "max_score", max_score, m_max());
    chk(min_idx == IDX_W'(m_min()), "R5", "min_idx", min_idx, m_min());
  endtask

  task automatic check_slot(input int s, input string req);
    rd_idx = IDX_W'(s);
    #1;
    chk(rd_valid == m_vld[s], req, $sformatf("slot %0d valid", s), rd_valid, m_vld[s]);
    if (m_vld[s]) begin
      chk(rd_tag == m_tag[s], req, $sformatf("slot %0d tag", s), rd_tag, m_tag[s]);
      chk(rd_score == SCORE_W'(m_scr[s]), req, $sformatf("slot %0d score", s), rd_score, m_scr[s]);
    end
  endtask

  // Driver: accepted insert, model update, expected eviction pushed to scoreboard
  task automatic do_ins(input logic [TAG_W-1:0] t, input int sc, input string req);
    int slot;
    slot = m_find(t);
    chk(ins_ready == 1'b1, req, "ins_ready before insert", ins_ready, 1);
    if (slot < 0) begin
      slot = -1;
      for (int i = ENTRIES - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
      if (slot < 0) begin
        slot = m_min();
        ev_q.push_back(m_tag[slot]);
      end
      m_vld[slot] = 1; m_tag[slot] = t; m_scr[slot] = sc;
    end
    ins_valid = 1; ins_tag = t; ins_score = SCORE_W'(sc);
    step();
    ins_valid = 0;
    check_rank(req);
    check_slot(slot, req);
  endtask

  task automatic do_del(input logic [TAG_W-1:0] t, input string req);
    int slot;
    slot = m_find(t);
    if (slot >= 0) m_vld[slot] = 0;
    del_valid = 1; del_tag = t;
    step();
    del_valid = 0;
    check_rank(req);
  endtask

  // Monitor: eviction handshakes compared against the scoreboard
  always @(negedge clk) begin
    if (rst_n && evict_valid && evict_ready) begin
      if (ev_q.size() == 0) begin
        chk(0, "R6", "unexpected eviction", evict_tag, 0);
      end else begin
        logic [TAG_W-1:0] e;
        e = ev_q.pop_front();
        chk(evict_tag == e, "R6", "evicted tag", evict_tag, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", "timeout", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int sc[ENTRIES] = '{5, 3, 7, 3, 9, 2, 2, 6};
    for (int i = 0; i < ENTRIES; i++) begin m_vld[i] = 0; m_tag[i] = '0; m_scr[i] = 0; end
    rst_n = 0; ins_valid = 0; ins_tag = '0; ins_score = '0;
    del_valid = 0; del_tag = '0; flush = 0; rd_idx = '0; evict_ready = 0;
    repeat (3) step();
    rst_n = 1;
    step();

    // R1 reset state
    chk(count == 0, "R1", "count", count, 0);
    chk(evict_valid == 0, "R1", "evict_valid", evict_valid, 0);
    chk(min_idx == 0, "R1", "min_idx", min_idx, 0);
    chk(max_score == 0, "R1", "max_score", max_score, 0);
    for (int i = 0; i < ENTRIES; i++) check_slot(i, "R1");

    // R2 fill with ties (3,3 and 2,2) to exercise R5 tie-break
    for (int i = 0; i < ENTRIES; i++) do_ins(TAG_W'(32'h100 + i), sc[i], "R2");

    // R3 duplicate tag with a different score
    do_ins(TAG_W'(32'h102), 15, "R3");
    chk(max_score == 4'd9, "R3", "max after dup", max_score, 9);

    // R6 overflow: slot 5 (score 2, lowest index of tie) replaced
    do_ins(TAG_W'(32'hABC), 8, "R6");
    chk(evict_valid == 1, "R6", "evict_valid", evict_valid, 1);
    chk(evict_tag == TAG_W'(32'h105), "R6", "evict_tag", evict_tag, 32'h105);

    // R7 request held while not ready; inserts blocked
    ins_valid = 1; ins_tag = TAG_W'(32'hDEF); ins_score = 4'd1;
    for (int k = 0; k < 3; k++) begin
      chk(ins_ready == 0, "R7", "ins_ready while pending", ins_ready, 0);
      step();
      chk(evict_valid == 1, "R7", "evict_valid held", evict_valid, 1);
      chk(evict_tag == TAG_W'(32'h105), "R7", "evict_tag held", evict_tag, 32'h105);
    end
    ins_valid = 0;
    chk(m_find(TAG_W'(32'hDEF)) < 0 && count == 8, "R7", "count after blocked insert", count, 8);
    evict_ready = 1;
    step();
    evict_ready = 0;
    chk(evict_valid == 0, "R7", "evict_valid drops", evict_valid, 0);
    chk(ev_q.size() == 0, "R6", "scoreboard drained", ev_q.size(), 0);
    for (int i = 0; i < ENTRIES; i++) check_slot(i, "R6");

    // R8 absent delete, then real delete of the max entry
    do_del(TAG_W'(32'h777), "R8");
    do_del(TAG_W'(32'h104), "R8");
    check_slot(4, "R8");

    // R9 delete and insert together
    del_valid = 1; del_tag = TAG_W'(32'h101);
    ins_valid = 1; ins_tag = TAG_W'(32'h555); ins_score = 4'd4;
    #1;
    chk(ins_ready == 0, "R9", "ins_ready during delete", ins_ready, 0);
    m_vld[1] = 0;
    step();
    del_valid = 0; ins_valid = 0;
    check_rank("R9");
    check_slot(1, "R9");

    // R2 lowest free slot (1 and 4 free)
    do_ins(TAG_W'(32'h200), 1, "R2");
    for (int i = 0; i < ENTRIES; i++) check_slot(i, "R2");

    // R10 flush with an insert presented
    flush = 1; ins_valid = 1; ins_tag = TAG_W'(32'h999); ins_score = 4'd12;
    #1;
    chk(ins_ready == 0, "R10", "ins_ready during flush", ins_ready, 0);
    for (int i = 0; i < ENTRIES; i++) m_vld[i] = 0;
    step();
    flush = 0; ins_valid = 0;
    check_rank("R10");
    for (int i = 0; i < ENTRIES; i++) check_slot(i, "R10");

    // R2 after flush: slot 0 again
    do_ins(TAG_W'(32'h321), 3, "R2");
    chk(rd_valid && rd_idx == 0, "R2", "slot 0 after flush", rd_idx, 0);

    repeat (2) step();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule